// File: doc/BRIEF.md
# Integer trap condition evaluator

This block decides whether a fixed-point conditional-trap operation must raise a trap. It receives a 64-bit register operand A, a second operand that is either a 64-bit register value or a 16-bit signed immediate, a 5-bit condition mask, and two mode flags. One flag picks word or doubleword width. The other picks register or immediate for the second operand. The block forms the two comparison operands. It then evaluates signed and unsigned relations between them and raises a trap flag when any relation enabled by the mask holds. The block modifies no flags or other state besides its own output register.

Operations enter on a valid/ready input stream. Results leave on a valid/ready output stream through a single registered stage. Back-pressure works as follows:
- An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result shows on `out_valid`/`trap` from the next cycle.
- `in_ready` is high whenever the output stage is empty or is being drained in the same cycle (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new input is taken.

Top module: `trap_cond_eval`

## Requirements
- R1: Mask bit 0 set raises a trap when A < B as two's-complement signed values.
- R2: Mask bit 1 set raises a trap when A > B as signed values.
- R3: Mask bit 2 set raises a trap when A equals B.
- R4: Mask bit 3 set raises a trap when A < B as unsigned values.
- R5: Mask bit 4 set raises a trap when A > B as unsigned values.
- R6: With `word_mode` high, each register operand is the sign extension to 64 bits of its low 32 bits. Bits 63:32 of the registers have no effect, and all five relations are evaluated on the extended values.
- R7: With `use_imm` high, B is `imm` sign-extended to 64 bits in both word and doubleword mode, and `opnd_b` has no effect. With `use_imm` low and `word_mode` low, both full register values are compared unchanged.
- R8: `trap` is the OR of all enabled relations. A zero mask never traps. A mask of 5'h1F always traps, since exactly one of signed-less, signed-greater and equal holds.
- R9: An accepted input produces `out_valid` high with its `trap` one cycle later. A synchronous reset (`rst` high) clears `out_valid` and `trap`.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, `out_valid` and `trap` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Block can accept an operation this cycle |
| opnd_a | input | 64 | Register operand A |
| opnd_b | input | 64 | Register operand B |
| imm | input | 16 | Signed immediate operand |
| cond_mask | input | 5 | Relation enable mask (bit0 s<, bit1 s>, bit2 =, bit3 u<, bit4 u>) |
| word_mode | input | 1 | 1: 32-bit sign-extended operands, 0: full 64-bit |
| use_imm | input | 1 | 1: B from `imm`, 0: B from `opnd_b` |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| trap | output | 1 | Trap decision for the held result |

## Verification
The first patterns are operand pairs with opposite signs. On these the signed and unsigned orders disagree, so a signed/unsigned swap on any mask bit is exposed. Word-mode pairs carry garbage in bits 63:32 and a set bit 31, which separates true sign extension from zero extension or use of the full register. Immediate vectors put a conflicting value on `opnd_b` and use negative immediates, which catches a missing operand mux or a zero-extended immediate. Zero, single-bit and all-ones masks, plus a long pseudo-random run with random `out_ready` stalls, cover the OR combine and the hold/accept rules of the output stage.

// File: rtl/trap_cond_pkg.sv
package trap_cond_pkg;
  localparam int REL_W   = 5;
  localparam int REL_SLT = 0;
  localparam int REL_SGT = 1;
  localparam int REL_EQ  = 2;
  localparam int REL_ULT = 3;
  localparam int REL_UGT = 4;
  typedef logic [REL_W-1:0] rel_vec_t;
endpackage

// File: rtl/trap_operand_prep.sv
module trap_operand_prep #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  a_raw,
  input  logic [XLEN-1:0]  b_raw,
  input  logic [IMM_W-1:0] imm,
  input  logic             word_mode,
  input  logic             use_imm,
  output logic [XLEN-1:0]  a_op,
  output logic [XLEN-1:0]  b_op
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] a_word, b_word, imm_ext;

  assign a_word  = {{(XLEN-HALF){a_raw[HALF-1]}}, a_raw[HALF-1:0]};
  assign b_word  = {{(XLEN-HALF){b_raw[HALF-1]}}, b_raw[HALF-1:0]};
  assign imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    a_op = word_mode ? a_word : a_raw;
    if (use_imm)        b_op = imm_ext;
    else if (word_mode) b_op = b_word;
    else                b_op = b_raw;
  end
endmodule

// File: rtl/trap_relation_unit.sv
module trap_relation_unit
  import trap_cond_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_op,
  input  logic [XLEN-1:0] b_op,
  output rel_vec_t        rel
);
  logic [XLEN:0] diff;
  logic          ult, slt, eq;

  assign diff = {1'b0, a_op} - {1'b0, b_op};
  assign ult  = diff[XLEN];
  assign eq   = (a_op == b_op);
  assign slt  = (a_op[XLEN-1] != b_op[XLEN-1]) ? a_op[XLEN-1] : ult;

  always_comb begin
    rel          = '0;
    rel[REL_SLT] = slt;
    rel[REL_SGT] = !slt && !eq;
    rel[REL_EQ]  = eq;
    rel[REL_ULT] = ult;
    rel[REL_UGT] = !ult && !eq;
  end
endmodule

// File: rtl/trap_mask_combine.sv
module trap_mask_combine
  import trap_cond_pkg::*;
(
  input  rel_vec_t   rel,
  input  rel_vec_t   mask,
  output logic       hit
);
  rel_vec_t enabled;

  for (genvar i = 0; i < REL_W; i++) begin : g_en
    assign enabled[i] = rel[i] & mask[i];
  end

  assign hit = |enabled;
endmodule

// File: rtl/trap_cond_eval.sv
module trap_cond_eval
  import trap_cond_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [XLEN-1:0]  opnd_a,
  input  logic [XLEN-1:0]  opnd_b,
  input  logic [IMM_W-1:0] imm,
  input  logic [REL_W-1:0] cond_mask,
  input  logic             word_mode,
  input  logic             use_imm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             trap
);
  logic [XLEN-1:0] a_op, b_op;
  rel_vec_t        rel;
  logic            hit;
  logic            accept;

  trap_operand_prep #(.XLEN(XLEN), .IMM_W(IMM_W)) u_prep (
    .a_raw(opnd_a), .b_raw(opnd_b), .imm(imm),
    .word_mode(word_mode), .use_imm(use_imm),
    .a_op(a_op), .b_op(b_op)
  );

  trap_relation_unit #(.XLEN(XLEN)) u_rel (
    .a_op(a_op), .b_op(b_op), .rel(rel)
  );

  trap_mask_combine u_comb (
    .rel(rel), .mask(cond_mask), .hit(hit)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      trap      <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) trap <= hit;
    end
  end

  // R8
  rel_partition_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ($countones(rel[2:0]) == 1 &&
                  $countones({rel[REL_ULT], rel[REL_UGT], rel[REL_EQ]}) == 1));

  // R8
  zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && cond_mask == '0) |=> !trap);

  // R8
  full_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && cond_mask == '1) |=> trap);

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(trap)));
endmodule

// File: tb/trap_cond_eval_bench.sv
`timescale 1ns/1ps
module trap_cond_eval_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_ready;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic [15:0] imm = '0;
  logic [4:0]  cond_mask = '0;
  logic        word_mode = 1'b0, use_imm = 1'b0;
  logic        out_valid, out_ready = 1'b1, trap;

  int    n_vec = 0, n_bad = 0;
  bit    stall_en = 1'b0;
  string cur_tag = "R9", exp_tag = "R9";
  logic  exp_valid = 1'b0, exp_trap = 1'b0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  trap_cond_eval u_trap_cond_eval (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .cond_mask(cond_mask),
    .word_mode(word_mode), .use_imm(use_imm),
    .out_valid(out_valid), .out_ready(out_ready), .trap(trap)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic ref_trap(input logic [63:0] a, input logic [63:0] b,
                                    input logic [15:0] im, input logic [4:0] m,
                                    input logic wm, input logic ui);
    longint sa, sb;
    logic [63:0] ua, ub;
    logic r;
    sa = wm ? longint'($signed(a[31:0])) : longint'(a);
    if (ui)      sb = longint'($signed(im));
    else if (wm) sb = longint'($signed(b[31:0]));
    else         sb = longint'(b);
    ua = 64'(sa);
    ub = 64'(sb);
    r = 1'b0;
    if (m[0] && sa <  sb) r = 1'b1;
    if (m[1] && sa >  sb) r = 1'b1;
    if (m[2] && sa == sb) r = 1'b1;
    if (m[3] && ua <  ub) r = 1'b1;
    if (m[4] && ua >  ub) r = 1'b1;
    return r;
  endfunction

  // Reference model, one update per clock edge
  always @(posedge clk) begin
    if (rst) begin
      exp_valid <= 1'b0;
      exp_trap  <= 1'b0;
    end else if (!exp_valid || out_ready) begin
      exp_valid <= in_valid;
      if (in_valid) begin
        exp_trap <= ref_trap(opnd_a, opnd_b, imm, cond_mask, word_mode, use_imm);
        exp_tag  <= cur_tag;
      end
    end
  end

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      n_vec++;
      if (out_valid !== exp_valid || trap !== exp_trap) begin
        n_bad++;
        $display("FAIL %s / R9 R10: out_valid=%b trap=%b expected out_valid=%b trap=%b",
                 exp_tag, out_valid, trap, exp_valid, exp_trap);
      end
      #2;
      n_vec++;
      if (in_ready !== (!exp_valid || out_ready)) begin
        n_bad++;
        $display("FAIL R10: in_ready=%b expected %b", in_ready, !exp_valid || out_ready);
      end
    end
  end

  // Consumer back-pressure
  always @(negedge clk) begin
    lfsr <= {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    out_ready <= stall_en ? lfsr[3] | lfsr[7] : 1'b1;
  end

  task automatic send(input logic [63:0] a, input logic [63:0] b, input logic [15:0] im,
                      input logic [4:0] m, input logic wm, input logic ui, input string tag);
    logic acc;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      opnd_a = a; opnd_b = b; imm = im; cond_mask = m;
      word_mode = wm; use_imm = ui; cur_tag = tag; in_valid = 1'b1;
      #1 acc = in_ready;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || trap !== 1'b0) begin
      n_bad++;
      $display("FAIL R9: reset out_valid=%b trap=%b expected 0 0", out_valid, trap);
    end
    @(negedge clk) rst = 1'b0;

    send(-64'sd5, 64'sd3, 16'h0, 5'b00001, 1'b0, 1'b0, "R1");
    send(64'sd3, -64'sd5, 16'h0, 5'b00001, 1'b0, 1'b0, "R1");
    send(64'sd3, -64'sd5, 16'h0, 5'b00010, 1'b0, 1'b0, "R2");
    send(-64'sd5, 64'sd3, 16'h0, 5'b00010, 1'b0, 1'b0, "R2");
    send(64'h1234, 64'h1234, 16'h0, 5'b00100, 1'b0, 1'b0, "R3");
    send(64'h1234, 64'h1235, 16'h0, 5'b00100, 1'b0, 1'b0, "R3");
    send(64'sd3, -64'sd5, 16'h0, 5'b01000, 1'b0, 1'b0, "R4");
    send(-64'sd5, 64'sd3, 16'h0, 5'b01000, 1'b0, 1'b0, "R4");
    send(-64'sd5, 64'sd3, 16'h0, 5'b10000, 1'b0, 1'b0, "R5");
    send(64'sd3, -64'sd5, 16'h0, 5'b10000, 1'b0, 1'b0, "R5");
    send(64'hFFFF_FFFF_0000_0001, 64'h0000_0000_0000_0001, 16'h0, 5'b00100, 1'b1, 1'b0, "R6");
    send(64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 16'h0, 5'b00001, 1'b1, 1'b0, "R6");
    send(64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 16'h0, 5'b00001, 1'b0, 1'b0, "R6");
    send(64'hDEAD_0000_8000_0000, 64'h5555_0000_0000_0001, 16'h0, 5'b10000, 1'b1, 1'b0, "R6");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'hFFFF, 5'b00100, 1'b0, 1'b1, "R7");
    send(64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 5'b00100, 1'b1, 1'b1, "R7");
    send(64'h0000_0000_0000_7FFF, 64'h0, 16'h8000, 5'b01000, 1'b0, 1'b1, "R7");
    send(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 16'h0, 5'b00000, 1'b0, 1'b0, "R8");
    send(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0, 5'b11111, 1'b0, 1'b0, "R8");
    send(64'h42, 64'h42, 16'h0, 5'b11011, 1'b0, 1'b0, "R8");

    stall_en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = (i % 5 == 0) ? ra : {$urandom, $urandom};
      send(ra, rb, 16'($urandom), 5'($urandom), 1'($urandom), 1'($urandom), "R8 R10");
      if ($urandom % 4 == 0) begin
        @(negedge clk) in_valid = 1'b0;
      end
    end
    @(negedge clk) in_valid = 1'b0;
    stall_en = 1'b0;
    repeat (6) @(negedge clk);

    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || trap !== 1'b0) begin
      n_bad++;
      $display("FAIL R9: reset out_valid=%b trap=%b expected 0 0", out_valid, trap);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule